// File: doc/BRIEF.md
# Prioritized nested interrupt controller

This block gathers the interrupt request lines of a processor subsystem: a parameterized number of peripheral lines and three fixed system exceptions (reset, non-maskable, hard fault). Each peripheral line has an enable bit and a small programmable urgency level. For every source the block also keeps a pending bit and an active bit. From the sources that are both pending and enabled, the block picks the most urgent one. It reports that source's exception number to the processor core and raises a preempt request whenever the chosen exception may interrupt the context that is currently running.

A write port configures the block. One kind of write sets enable bits, another clears them, and a third loads the urgency of one line from a byte. The core talks back through two strobes. An acknowledge strobe enters the offered exception. A return strobe leaves the innermost handler. The block keeps a stack of the active exceptions so that handlers can nest. During a return it also tells the core whether the next exception can be entered at once (tail-chaining), without first going back to the interrupted context.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every line is disabled, every urgency level reads 0, no source is pending or active, and `exc_valid_o`, `preempt_o` and `tail_chain_o` are low.
- R2: A write of kind 0 (enable-set) to word index w sets the enable of line 32*w+b for every 1 bit b of the data and changes no other enable. A write of kind 1 (enable-clear) clears the same lines in the same way.
- R3: A write of kind 2 to line index n keeps data bits [7:5] as the urgency of line n. `rd_prio_o` returns the level in bits [7:5] and zero in bits [4:0], so 0xC0 reads back as 0xC0 and 0xFF reads back as 0xE0.
- R4: The block offers the pending and enabled source with the lowest urgency value. Between equal values, the lower line index wins. A disabled line still becomes pending but is never offered.
- R5: The three system sources are always enabled and rank above every programmable level, with reset (`sys_req_i[0]`, number 1) first, then non-maskable (`sys_req_i[1]`, number 2), then hard fault (`sys_req_i[2]`, number 3). Peripheral line n is reported as exception number n+16.
- R6: `preempt_o` is high exactly when an exception is offered and either nothing is active or the offered urgency is strictly more urgent than that of the innermost active exception. An equal level waits.
- R7: When `ack_i` is high while `preempt_o` is high, the offered source stops pending and becomes active at the next clock edge. When `preempt_o` is low, `ack_i` is ignored.
- R8: `ret_i` retires the most recently acknowledged exception still active and clears its active bit. Exceptions entered earlier stay active.
- R9: During a `ret_i` cycle, `tail_chain_o` is high when the offered exception would preempt the context that remains after the retirement. If nothing would remain, any offered exception qualifies.
- R10: A high request on a line that is not active sets the line's pending bit, and the bit stays set after the request drops. While the line is active, its request does not set the bit. If the request is still held, the line is pending again two clock edges after its return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_LINES | Level requests of the peripheral lines |
| sys_req_i | input | 3 | Requests: bit 0 reset, bit 1 non-maskable, bit 2 hard fault |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_kind_i | input | 2 | 0 enable-set, 1 enable-clear, 2 urgency byte |
| wr_idx_i | input | clog2(NUM_LINES) | Word index (enable writes) or line index (urgency writes) |
| wr_data_i | input | 32 | Write data |
| rd_line_i | input | clog2(NUM_LINES) | Line inspected by the read outputs |
| rd_prio_o | output | 8 | Urgency byte of the inspected line |
| rd_en_o | output | 1 | Enable of the inspected line |
| rd_pend_o | output | 1 | Pending bit of the inspected line |
| rd_act_o | output | 1 | Active bit of the inspected line |
| ack_i | input | 1 | Core enters the offered exception |
| ret_i | input | 1 | Core leaves the innermost handler |
| exc_num_o | output | EXC_W | Number of the offered exception, 0 if none |
| exc_valid_o | output | 1 | An exception is offered |
| preempt_o | output | 1 | The offered exception may preempt now |
| tail_chain_o | output | 1 | Return can chain directly into the offered exception |

## Verification
The bench builds the block with its default parameters: 53 lines, 3 urgency bits, and an active stack eleven deep. With these values the lines span two enable words, so the vectors can place competitors in both words and at line 52, the last one. All eight levels and the three system ranks can compete for the choice. Nesting two deep is enough to reach both an equal-level tail-chain refusal and an empty-context tail-chain.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    WK_EN_SET = 2'd0,
    WK_EN_CLR = 2'd1,
    WK_PRIO   = 2'd2,
    WK_NONE   = 2'd3
  } wr_kind_e;

  localparam int SYS_SRC       = 3;
  localparam int LINE_EXC_BASE = 16;
  localparam int WORD_BITS     = 32;
endpackage

// File: rtl/nic_cfg.sv
module nic_cfg
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 53,
  parameter int PRIO_BITS = 3,
  parameter int IDX_W     = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en_i,
  input  logic [1:0]                           wr_kind_i,
  input  logic [IDX_W-1:0]                     wr_idx_i,
  input  logic [WORD_BITS-1:0]                 wr_data_i,
  output logic [NUM_LINES-1:0]                 en_o,
  output logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio_o
);

  wr_kind_e                              kind;
  logic [NUM_LINES-1:0]                  en_q, en_d;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0]   prio_q, prio_d;

  assign kind = wr_kind_e'(wr_kind_i);

  always_comb begin
    en_d   = en_q;
    prio_d = prio_q;
    for (int n = 0; n < NUM_LINES; n++) begin
      if ((n / WORD_BITS) == int'(wr_idx_i) && wr_data_i[n % WORD_BITS]) begin
        if (kind == WK_EN_SET) en_d[n] = 1'b1;
        if (kind == WK_EN_CLR) en_d[n] = 1'b0;
      end
      if (kind == WK_PRIO && int'(wr_idx_i) == n)
        prio_d[n] = wr_data_i[7 -: PRIO_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
    end else if (wr_en_i) begin
      en_q   <= en_d;
      prio_q <= prio_d;
    end
  end

  assign en_o   = en_q;
  assign prio_o = prio_q;

  // R2: an enable-set write never removes an enable
  a_r2_set_only_adds : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind == WK_EN_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R2: an enable-clear write never adds an enable
  a_r2_clear_only_removes : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind == WK_EN_CLR) |=> ((en_q | $past(en_q)) == $past(en_q)));

endmodule

// File: rtl/nic_select.sv
module nic_select #(
  parameter int N_SRC  = 56,
  parameter int EXT_W  = 4,
  parameter int SIDX_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][EXT_W-1:0]  prio_i,
  output logic                         valid_o,
  output logic [SIDX_W-1:0]            idx_o,
  output logic [EXT_W-1:0]             prio_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int s = 0; s < N_SRC; s++) begin
      // strict compare keeps the lower index on a tie
      if (cand_i[s] && (!valid_o || prio_i[s] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = SIDX_W'(s);
        prio_o  = prio_i[s];
      end
    end
  end

  // R4: the winner is always a live candidate
  a_r4_winner_is_candidate : assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> cand_i[idx_o]);

  // R4: no candidates means no winner
  a_r4_empty_no_winner : assert property (@(posedge clk) disable iff (!rst_n)
    (cand_i == '0) |-> !valid_o);

endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
  parameter int DEPTH  = 11,
  parameter int SIDX_W = 6,
  parameter int EXT_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [SIDX_W-1:0] push_idx_i,
  input  logic [EXT_W-1:0]  push_prio_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [SIDX_W-1:0] top_idx_o,
  output logic [EXT_W-1:0]  top_prio_o,
  output logic              below_valid_o,
  output logic [EXT_W-1:0]  below_prio_o
);

  logic [CNT_W-1:0]              cnt_q, cnt_d;
  logic [DEPTH-1:0][SIDX_W-1:0]  idx_q, idx_d;
  logic [DEPTH-1:0][EXT_W-1:0]   prio_q, prio_d;

  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    prio_d = prio_q;
    if (push_i && int'(cnt_q) < DEPTH) begin
      idx_d[cnt_q]  = push_idx_i;
      prio_d[cnt_q] = push_prio_i;
      cnt_d         = cnt_q + CNT_W'(1);
    end else if (pop_i && cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      prio_q <= '0;
    end else if (push_i || pop_i) begin
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      prio_q <= prio_d;
    end
  end

  assign empty_o       = (cnt_q == '0);
  assign full_o        = (int'(cnt_q) >= DEPTH);
  assign top_idx_o     = empty_o ? '0 : idx_q[cnt_q - CNT_W'(1)];
  assign top_prio_o    = empty_o ? '1 : prio_q[cnt_q - CNT_W'(1)];
  assign below_valid_o = (int'(cnt_q) >= 2);
  assign below_prio_o  = below_valid_o ? prio_q[cnt_q - CNT_W'(2)] : '1;

  // R6: each nested entry is strictly more urgent than the one beneath
  a_r6_push_more_urgent : assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !empty_o) |-> (push_prio_i < top_prio_o));

  // R8: the stack never grows past its depth
  a_r8_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  // R7: entry and exit never coincide
  a_r7_push_pop_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 53,
  parameter int PRIO_BITS = 3,
  parameter int EXC_W     = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [SYS_SRC-1:0]   sys_req_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_kind_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [31:0]          wr_data_i,
  input  logic [IDX_W-1:0]     rd_line_i,
  output logic [7:0]           rd_prio_o,
  output logic                 rd_en_o,
  output logic                 rd_pend_o,
  output logic                 rd_act_o,
  input  logic                 ack_i,
  input  logic                 ret_i,
  output logic [EXC_W-1:0]     exc_num_o,
  output logic                 exc_valid_o,
  output logic                 preempt_o,
  output logic                 tail_chain_o
);

  localparam int N_SRC       = NUM_LINES + SYS_SRC;
  localparam int SIDX_W      = $clog2(N_SRC);
  localparam int EXT_W       = PRIO_BITS + 1;
  localparam int STACK_DEPTH = (1 << PRIO_BITS) + SYS_SRC;
  localparam int CNT_W       = $clog2(STACK_DEPTH + 1);

  logic [NUM_LINES-1:0]                 line_en;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0]  line_prio;
  logic [N_SRC-1:0]                     src_req, src_en, cand;
  logic [N_SRC-1:0][EXT_W-1:0]          src_prio;
  logic [N_SRC-1:0]                     pend_q, pend_d, act_q, act_d;
  logic                                 sel_valid;
  logic [SIDX_W-1:0]                    sel_idx;
  logic [EXT_W-1:0]                     sel_prio;
  logic                                 stk_empty, stk_full, below_valid;
  logic [SIDX_W-1:0]                    top_idx;
  logic [EXT_W-1:0]                     top_prio, below_prio;
  logic                                 accept, retire;
  logic                                 rd_ok;
  logic [SIDX_W-1:0]                    rd_src;

  nic_cfg #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS),
    .IDX_W     (IDX_W)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .en_o      (line_en),
    .prio_o    (line_prio)
  );

  // unified source vector: system exceptions first, then peripheral lines
  assign src_req = {irq_i, sys_req_i};
  assign src_en  = {line_en, {SYS_SRC{1'b1}}};

  for (genvar s = 0; s < N_SRC; s++) begin : g_rank
    if (s < SYS_SRC) begin : g_sys
      assign src_prio[s] = {1'b0, PRIO_BITS'(s)};
    end else begin : g_line
      assign src_prio[s] = {1'b1, line_prio[s - SYS_SRC]};
    end
  end

  assign cand = pend_q & src_en;

  nic_select #(
    .N_SRC  (N_SRC),
    .EXT_W  (EXT_W),
    .SIDX_W (SIDX_W)
  ) i_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand_i  (cand),
    .prio_i  (src_prio),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .prio_o  (sel_prio)
  );

  assign preempt_o = sel_valid && !stk_full && (stk_empty || sel_prio < top_prio);
  assign accept    = ack_i && !ret_i && preempt_o;
  assign retire    = ret_i && !stk_empty;

  nic_stack #(
    .DEPTH  (STACK_DEPTH),
    .SIDX_W (SIDX_W),
    .EXT_W  (EXT_W),
    .CNT_W  (CNT_W)
  ) i_stack (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (accept),
    .pop_i         (retire),
    .push_idx_i    (sel_idx),
    .push_prio_i   (sel_prio),
    .empty_o       (stk_empty),
    .full_o        (stk_full),
    .top_idx_o     (top_idx),
    .top_prio_o    (top_prio),
    .below_valid_o (below_valid),
    .below_prio_o  (below_prio)
  );

  // pending / active next state
  always_comb begin
    pend_d = pend_q | (src_req & ~act_q);
    act_d  = act_q;
    if (accept) begin
      pend_d[sel_idx] = 1'b0;
      act_d[sel_idx]  = 1'b1;
    end
    if (retire) act_d[top_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign tail_chain_o = retire && sel_valid && (!below_valid || sel_prio < below_prio);

  assign exc_valid_o = sel_valid;
  assign exc_num_o   = !sel_valid ? '0 :
                       (int'(sel_idx) < SYS_SRC) ? EXC_W'(int'(sel_idx) + 1) :
                       EXC_W'(int'(sel_idx) + LINE_EXC_BASE - SYS_SRC);

  // inspection port
  assign rd_ok     = int'(rd_line_i) < NUM_LINES;
  assign rd_src    = SIDX_W'(int'(rd_line_i) + SYS_SRC);
  assign rd_prio_o = rd_ok ? {line_prio[rd_line_i], (8 - PRIO_BITS)'(0)} : 8'h00;
  assign rd_en_o   = rd_ok && line_en[rd_line_i];
  assign rd_pend_o = rd_ok && pend_q[rd_src];
  assign rd_act_o  = rd_ok && act_q[rd_src];

  // R7: an accepted exception is active and no longer pending
  a_r7_ack_activates : assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (act_q[$past(sel_idx)] && !pend_q[$past(sel_idx)]));

  // R8: the retired exception leaves the active set
  a_r8_ret_clears : assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !act_q[$past(top_idx)]);

  // R10: a source is never pending and active at once
  a_r10_active_not_pending : assert property (@(posedge clk) disable iff (!rst_n)
    (act_q & pend_q) == '0);

  // R9: a tail-chain is only offered when an exception is waiting
  a_r9_tail_has_target : assert property (@(posedge clk) disable iff (!rst_n)
    tail_chain_o |-> (exc_valid_o && ret_i));

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  import nic_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NL         = 53;

  typedef struct packed {
    logic [5:0] la;
    logic [7:0] pa;
    logic [5:0] lb;
    logic [7:0] pb;
    logic [2:0] sys;
    logic [7:0] exp_num;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'd5,  8'h40, 6'd9,  8'h20, 3'b000, 8'd25},  // lower value wins
    '{6'd5,  8'h60, 6'd9,  8'h60, 3'b000, 8'd21},  // tie: lower index
    '{6'd40, 8'h00, 6'd7,  8'hE0, 3'b000, 8'd56},  // second enable word
    '{6'd52, 8'h00, 6'd0,  8'hFF, 3'b000, 8'd68},  // last line, level 0
    '{6'd3,  8'h00, 6'd4,  8'h00, 3'b100, 8'd3},   // hard fault over level 0
    '{6'd3,  8'h00, 6'd4,  8'h00, 3'b110, 8'd2},   // non-maskable over hard fault
    '{6'd3,  8'h00, 6'd4,  8'h00, 3'b111, 8'd1},   // reset first
    '{6'd10, 8'h1F, 6'd2,  8'h20, 3'b000, 8'd26}   // low bits ignored
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic [NL-1:0] irq;
  logic [2:0]    sys;
  logic          wr_en;
  logic [1:0]    wr_kind;
  logic [5:0]    wr_idx;
  logic [31:0]   wr_data;
  logic [5:0]    rd_line;
  logic [7:0]    rd_prio;
  logic          rd_en, rd_pend, rd_act;
  logic          ack, ret;
  logic [7:0]    exc_num;
  logic          exc_valid, preempt, tail;

  int n_chk  = 0;
  int n_fail = 0;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_i        (irq),
    .sys_req_i    (sys),
    .wr_en_i      (wr_en),
    .wr_kind_i    (wr_kind),
    .wr_idx_i     (wr_idx),
    .wr_data_i    (wr_data),
    .rd_line_i    (rd_line),
    .rd_prio_o    (rd_prio),
    .rd_en_o      (rd_en),
    .rd_pend_o    (rd_pend),
    .rd_act_o     (rd_act),
    .ack_i        (ack),
    .ret_i        (ret),
    .exc_num_o    (exc_num),
    .exc_valid_o  (exc_valid),
    .preempt_o    (preempt),
    .tail_chain_o (tail)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(wr_kind_e k, int idx, logic [31:0] d);
    wr_en = 1'b1; wr_kind = k; wr_idx = 6'(idx); wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic line_en(int line, bit on);
    wr(on ? WK_EN_SET : WK_EN_CLR, line / 32, 32'(1) << (line % 32));
  endtask

  task automatic pulse(logic [NL-1:0] m, logic [2:0] s);
    irq = m; sys = s;
    cyc();
    irq = '0; sys = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; cyc(); ret = 1'b0;
  endtask

  task automatic peek(int line);
    rd_line = 6'(line);
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) begin
      if (exc_valid) begin
        do_ack();
        do_ret();
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    irq = '0; sys = '0; wr_en = 1'b0; wr_kind = 2'd3; wr_idx = '0;
    wr_data = '0; rd_line = '0; ack = 1'b0; ret = 1'b0; rst_n = 1'b0;
    do_reset();

    // R1: reset state
    peek(20);
    chk("R1 exc_valid", exc_valid, 0);
    chk("R1 preempt", preempt, 0);
    chk("R1 tail", tail, 0);
    chk("R1 prio", rd_prio, 0);
    chk("R1 enable", rd_en, 0);
    chk("R1 pend/act", {rd_pend, rd_act}, 0);

    // vector table: R4 R5 selection
    for (int v = 0; v < NV; v++) begin
      logic [NL-1:0] m;
      wr(WK_PRIO, int'(VECS[v].la), 32'(VECS[v].pa));
      wr(WK_PRIO, int'(VECS[v].lb), 32'(VECS[v].pb));
      line_en(int'(VECS[v].la), 1'b1);
      line_en(int'(VECS[v].lb), 1'b1);
      m = '0;
      m[VECS[v].la] = 1'b1;
      m[VECS[v].lb] = 1'b1;
      pulse(m, VECS[v].sys);
      chk($sformatf("R4 R5 vector %0d number", v), exc_num, int'(VECS[v].exp_num));
      chk($sformatf("R6 vector %0d preempt idle", v), preempt, 1);
      drain();
      line_en(int'(VECS[v].la), 1'b0);
      line_en(int'(VECS[v].lb), 1'b0);
      chk($sformatf("R7 R8 vector %0d drained", v), exc_valid, 0);
    end

    do_reset();

    // R3: urgency byte keeps top bits only
    wr(WK_PRIO, 7, 32'h0000_00C0);
    wr(WK_PRIO, 8, 32'h0000_00FF);
    peek(7);  chk("R3 0xC0 readback", rd_prio, 8'hC0);
    peek(8);  chk("R3 0xFF readback", rd_prio, 8'hE0);

    // R2: set/clear leave zero bits alone
    wr(WK_EN_SET, 1, 32'h0000_0100);        // line 40
    wr(WK_EN_SET, 1, 32'h0000_0004);        // line 34
    peek(40); chk("R2 set keeps line 40", rd_en, 1);
    peek(34); chk("R2 set line 34", rd_en, 1);
    wr(WK_EN_CLR, 1, 32'h0000_0004);
    peek(34); chk("R2 clear line 34", rd_en, 0);
    peek(40); chk("R2 clear keeps line 40", rd_en, 1);
    peek(8);  chk("R2 word 0 untouched", rd_en, 0);

    // R4: disabled line pends but is not offered
    begin
      logic [NL-1:0] m;
      m = '0; m[34] = 1'b1;
      pulse(m, 3'b000);
    end
    peek(34); chk("R4 disabled pends", rd_pend, 1);
    chk("R4 disabled not offered", exc_valid, 0);
    line_en(34, 1'b1);
    chk("R5 line 34 number", exc_num, 50);
    do_ack();
    peek(34);
    chk("R7 ack activates", rd_act, 1);
    chk("R7 ack clears pending", rd_pend, 0);
    do_ret();
    peek(34); chk("R8 return clears active", rd_act, 0);
    line_en(34, 1'b0);
    line_en(40, 1'b0);

    // R6 R7 R8 R9: nesting
    wr(WK_PRIO, 1, 32'h80);
    wr(WK_PRIO, 2, 32'h80);
    wr(WK_PRIO, 3, 32'h40);
    wr(WK_EN_SET, 0, 32'h0000_000E);
    pulse(NL'(1) << 1, 3'b000);
    chk("R5 line 1 number", exc_num, 17);
    do_ack();
    pulse(NL'(1) << 2, 3'b000);
    chk("R4 line 2 offered", exc_num, 18);
    chk("R6 equal level waits", preempt, 0);
    do_ack();
    peek(2);
    chk("R7 ignored ack keeps pending", rd_pend, 1);
    chk("R7 ignored ack no active", rd_act, 0);
    pulse(NL'(1) << 3, 3'b000);
    chk("R6 more urgent preempts", preempt, 1);
    chk("R4 line 3 offered", exc_num, 19);
    do_ack();
    ret = 1'b1; #1;
    chk("R9 no chain at equal level", tail, 0);
    cyc(); ret = 1'b0;
    peek(3); chk("R8 innermost retired", rd_act, 0);
    peek(1); chk("R8 outer still active", rd_act, 1);
    ret = 1'b1; #1;
    chk("R9 chain into empty context", tail, 1);
    cyc(); ret = 1'b0;
    peek(1); chk("R8 outer retired", rd_act, 0);
    drain();

    // R10: held request
    irq[3] = 1'b1;
    cyc();
    peek(3); chk("R10 request pends", rd_pend, 1);
    do_ack();
    cyc();
    peek(3); chk("R10 no pend while active", rd_pend, 0);
    do_ret();
    peek(3); chk("R10 not yet pending", rd_pend, 0);
    cyc();
    peek(3); chk("R10 re-pends after return", rd_pend, 1);
    irq[3] = 1'b0;
    cyc();
    peek(3); chk("R10 pending is sticky", rd_pend, 1);
    drain();
    chk("R10 drained", exc_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule